// File: doc/BRIEF.md
# USB Device Endpoint Interrupt Controller

This block sits beside the serial interface engine of a USB device. It takes a one-cycle result strobe for every finished endpoint transaction, plus single-cycle strobes for bus reset, start-of-frame, ID-pin change and VBUS change. It records each of these as a sticky flag in a 16-bit status register. Software clears a flag by writing 1 to its bit. A single interrupt request is raised while any flag is set whose enable bit is also set.

The block also holds the 7-bit device address assigned by the host. From the token address on the bus it derives a combinational match signal, which the packet engine uses to drop tokens sent to other devices. All registers are reached through a plain 16-bit register port. A write happens on the clock edge when the write strobe is high. Read data is combinational, selected by the register address.

Register map (2-bit address): 0 is the interrupt enable register, which has the same bit layout as status. 1 holds the per-endpoint NAK enables, bit n for endpoint n. 2 holds the device address in bits 6:0. 3 is the status register.

Top module: `usb_dev_irq_ctrl`

## Requirements
- R1: An endpoint result strobe with result code ACK (0), STALL (2), TIMEOUT (3), IN error (4) or OUT error (5) sets status bit n for endpoint n at the next clock edge. This happens whatever the enable setting.
- R2: A NAK result (code 1) sets the endpoint's flag only when bit n of the NAK enable register (address 1) is 1. Codes 6 and 7 set nothing.
- R3: Bus event strobes set status bits at the next edge: bus reset sets bit 8, SOF/EOP sets bit 9, ID sets bit 14 and VBUS sets bit 15.
- R4: Writing the status register (address 3) clears every flag written with 1. Flags written with 0 keep their value.
- R5: When a set event and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R6: Status bits 13:10 and enable bits 13:10 always read 0. Writes to those bits have no effect.
- R7: The interrupt output is a register. After each clock edge it equals the OR over all status bits ANDed with their enable bits, so it rises in the cycle after the event strobe.
- R8: The device address (address 2, bits 6:0) resets to 0, changes only by a register write, and the written value reads back after the next edge. Bits 15:7 of the write are ignored.
- R9: The address-match output is high, combinationally, exactly when the token address equals the stored device address. This includes token 0 while the stored address is 0.
- R10: After reset, all four registers read 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| ep_evt_valid | input | 1 | Endpoint result strobe |
| ep_evt_num | input | 3 | Endpoint number of the result |
| ep_evt_res | input | 3 | Result code |
| bus_reset_evt | input | 1 | Bus reset detected strobe |
| sof_evt | input | 1 | SOF/EOP strobe |
| id_evt | input | 1 | ID pin change strobe |
| vbus_evt | input | 1 | VBUS change strobe |
| tok_addr | input | 7 | Address field of the current token |
| addr_match | output | 1 | Token addressed to this device |
| irq | output | 1 | Interrupt request |

## Verification
Every register result of this block appears in the cycle after its stimulus: status flags, enables, NAK enables, the device address and the interrupt all change on the first clock edge after the strobe or write. Read data and the address match are combinational from those registers and the current inputs. The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares read data, interrupt and match on the following falling edge, so each comparison sees exactly one edge of register update. Reset release passes a two-stage synchronizer, so the model stays idle for three cycles after release before the first comparison.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int REG_DW = 16;
  localparam int REG_AW = 2;

  typedef enum logic [2:0] {
    RES_ACK    = 3'd0,
    RES_NAK    = 3'd1,
    RES_STALL  = 3'd2,
    RES_TMO    = 3'd3,
    RES_INERR  = 3'd4,
    RES_OUTERR = 3'd5
  } xfer_res_e;

  localparam int BIT_BUSRST = 8;
  localparam int BIT_SOF    = 9;
  localparam int BIT_ID     = 14;
  localparam int BIT_VBUS   = 15;

  localparam logic [REG_AW-1:0] RA_IEN   = 2'd0;
  localparam logic [REG_AW-1:0] RA_NAKEN = 2'd1;
  localparam logic [REG_AW-1:0] RA_ADDR  = 2'd2;
  localparam logic [REG_AW-1:0] RA_STAT  = 2'd3;
endpackage

// File: rtl/usb_rst_sync.sv
module usb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/usb_ep_done_decode.sv
module usb_ep_done_decode
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic              evt_valid,
  input  logic [EPW-1:0]    evt_ep,
  input  logic [2:0]        evt_res,
  input  logic [NUM_EP-1:0] nak_en,
  output logic [NUM_EP-1:0] done_set
);
  logic res_counts;

  // a result counts as "done" on a fixed outcome set; NAK only when enabled
  always_comb begin
    case (evt_res)
      RES_ACK, RES_STALL, RES_TMO, RES_INERR, RES_OUTERR: res_counts = 1'b1;
      RES_NAK: res_counts = nak_en[evt_ep];
      default: res_counts = 1'b0;
    endcase
  end

  for (genvar gi = 0; gi < NUM_EP; gi++) begin : g_ep
    assign done_set[gi] = evt_valid && res_counts && (evt_ep == EPW'(gi));
  end
endmodule

// File: rtl/usb_stat_reg.sv
module usb_stat_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, stat_d, clr_mask;

  always_comb begin
    clr_mask = clr_we ? (clr_data & MASK) : '0;
    // set is OR-ed after the clear, so a same-cycle set wins
    stat_d   = (stat_q & ~clr_mask) | (set_i & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/usb_dev_addr.sv
module usb_dev_addr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] tok_addr,
  output logic [AW-1:0] addr_o,
  output logic          match_o
);
  logic [AW-1:0] addr_q, addr_d;

  always_comb addr_d = wr_en ? wr_data : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o  = addr_q;
  assign match_o = (tok_addr == addr_q);
endmodule

// File: rtl/usb_dev_irq_ctrl.sv
module usb_dev_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int NUM_EP  = 8,
  parameter int DEV_AW  = 7,
  localparam int EPW    = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              ep_evt_valid,
  input  logic [EPW-1:0]    ep_evt_num,
  input  logic [2:0]        ep_evt_res,
  input  logic              bus_reset_evt,
  input  logic              sof_evt,
  input  logic              id_evt,
  input  logic              vbus_evt,
  input  logic [DEV_AW-1:0] tok_addr,
  output logic              addr_match,
  output logic              irq
);
  localparam logic [REG_DW-1:0] EP_MASK   = REG_DW'((1 << NUM_EP) - 1);
  localparam logic [REG_DW-1:0] STAT_MASK = EP_MASK
                                          | (REG_DW'(1) << BIT_BUSRST)
                                          | (REG_DW'(1) << BIT_SOF)
                                          | (REG_DW'(1) << BIT_ID)
                                          | (REG_DW'(1) << BIT_VBUS);

  logic              rst_n_s;
  logic [REG_DW-1:0] ien_q, ien_d;
  logic [NUM_EP-1:0] nak_en_q, nak_en_d;
  logic [NUM_EP-1:0] done_set;
  logic [REG_DW-1:0] set_vec, stat_q;
  logic [DEV_AW-1:0] dev_addr_q;
  logic              irq_q, irq_d;
  logic              wr_ien, wr_nak, wr_addr, wr_stat;

  usb_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  assign wr_ien  = reg_we && (reg_addr == RA_IEN);
  assign wr_nak  = reg_we && (reg_addr == RA_NAKEN);
  assign wr_addr = reg_we && (reg_addr == RA_ADDR);
  assign wr_stat = reg_we && (reg_addr == RA_STAT);

  usb_ep_done_decode #(.NUM_EP(NUM_EP)) u_decode (
    .evt_valid (ep_evt_valid),
    .evt_ep    (ep_evt_num),
    .evt_res   (ep_evt_res),
    .nak_en    (nak_en_q),
    .done_set  (done_set)
  );

  always_comb begin
    set_vec                 = '0;
    set_vec[NUM_EP-1:0]     = done_set;
    set_vec[BIT_BUSRST]     = bus_reset_evt;
    set_vec[BIT_SOF]        = sof_evt;
    set_vec[BIT_ID]         = id_evt;
    set_vec[BIT_VBUS]       = vbus_evt;
  end

  usb_stat_reg #(.W(REG_DW), .MASK(STAT_MASK)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .set_i    (set_vec),
    .clr_we   (wr_stat),
    .clr_data (reg_wdata),
    .stat_o   (stat_q)
  );

  usb_dev_addr #(.AW(DEV_AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_addr),
    .wr_data  (reg_wdata[DEV_AW-1:0]),
    .tok_addr (tok_addr),
    .addr_o   (dev_addr_q),
    .match_o  (addr_match)
  );

  // enable registers, next state
  always_comb begin
    ien_d    = wr_ien ? (reg_wdata & STAT_MASK) : ien_q;
    nak_en_d = wr_nak ? reg_wdata[NUM_EP-1:0] : nak_en_q;
  end

  // interrupt computed from the flags and enables they will hold after this edge
  always_comb begin
    irq_d = |(((stat_q & ~(wr_stat ? (reg_wdata & STAT_MASK) : '0))
              | (set_vec & STAT_MASK)) & ien_d);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ien_q    <= '0;
      nak_en_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      ien_q    <= ien_d;
      nak_en_q <= nak_en_d;
      irq_q    <= irq_d;
    end
  end

  assign irq = irq_q;

  always_comb begin
    case (reg_addr)
      RA_IEN:   reg_rdata = ien_q;
      RA_NAKEN: reg_rdata = {{(REG_DW-NUM_EP){1'b0}}, nak_en_q};
      RA_ADDR:  reg_rdata = {{(REG_DW-DEV_AW){1'b0}}, dev_addr_q};
      default:  reg_rdata = stat_q;
    endcase
  end
endmodule

// File: rtl/usb_irq_chk.sv
module usb_irq_chk
  import usb_irq_pkg::*;
(
  input logic        clk,
  input logic        rst_n_s,
  input logic        ep_evt_valid,
  input logic [2:0]  ep_evt_num,
  input logic [2:0]  ep_evt_res,
  input logic [7:0]  nak_en_q,
  input logic [15:0] stat_q,
  input logic [15:0] ien_q,
  input logic        bus_reset_evt,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic [6:0]  dev_addr_q,
  input logic        irq
);
  // R1
  ack_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ep_evt_valid && ep_evt_res == RES_ACK) |=> stat_q[$past(ep_evt_num)]);

  // R2
  nak_masked_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ep_evt_valid && ep_evt_res == RES_NAK && !nak_en_q[ep_evt_num]
     && !stat_q[ep_evt_num]) |=> !stat_q[$past(ep_evt_num)]);

  // R3
  busrst_source_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(stat_q[BIT_BUSRST]) |-> $past(bus_reset_evt));

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_reset_evt && reg_we && reg_addr == RA_STAT && reg_wdata[BIT_BUSRST])
    |=> stat_q[BIT_BUSRST]);

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (stat_q[13:10] == 4'b0) && (ien_q[13:10] == 4'b0));

  // R7
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq) |-> |(stat_q & ien_q));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(reg_we && reg_addr == RA_ADDR) |=> $stable(dev_addr_q));
endmodule

bind usb_dev_irq_ctrl usb_irq_chk u_irq_chk (
  .clk           (clk),
  .rst_n_s       (rst_n_s),
  .ep_evt_valid  (ep_evt_valid),
  .ep_evt_num    (ep_evt_num),
  .ep_evt_res    (ep_evt_res),
  .nak_en_q      (nak_en_q),
  .stat_q        (stat_q),
  .ien_q         (ien_q),
  .bus_reset_evt (bus_reset_evt),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .dev_addr_q    (dev_addr_q),
  .irq           (irq)
);

// File: tb/usb_dev_irq_ctrl_bench.sv
module usb_dev_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_we;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        ep_evt_valid;
  logic [2:0]  ep_evt_num;
  logic [2:0]  ep_evt_res;
  logic        bus_reset_evt, sof_evt, id_evt, vbus_evt;
  logic [6:0]  tok_addr;
  logic        addr_match;
  logic        irq;

  always #5 clk = ~clk;

  usb_dev_irq_ctrl u_usb_dev_irq_ctrl (.*);

  localparam logic [15:0] SMASK = 16'hC3FF;

  int    vectors = 0;
  int    errors  = 0;
  string tag     = "R10";

  // behavioural reference state
  logic [15:0] m_ien, m_stat;
  logic [7:0]  m_nak;
  logic [6:0]  m_addr;
  logic        m_irq;
  bit          m_live = 0;

  task automatic cmp(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [15:0] set_m, clr_m;
    set_m = 16'h0;
    if (ep_evt_valid) begin
      if (ep_evt_res inside {3'd0, 3'd2, 3'd3, 3'd4, 3'd5})
        set_m[ep_evt_num] = 1'b1;
      else if (ep_evt_res == 3'd1 && m_nak[ep_evt_num])
        set_m[ep_evt_num] = 1'b1;
    end
    if (bus_reset_evt) set_m[8]  = 1'b1;
    if (sof_evt)       set_m[9]  = 1'b1;
    if (id_evt)        set_m[14] = 1'b1;
    if (vbus_evt)      set_m[15] = 1'b1;
    clr_m = (reg_we && reg_addr == 2'd3) ? (reg_wdata & SMASK) : 16'h0;
    if (reg_we && reg_addr == 2'd0) m_ien  = reg_wdata & SMASK;
    if (reg_we && reg_addr == 2'd1) m_nak  = reg_wdata[7:0];
    if (reg_we && reg_addr == 2'd2) m_addr = reg_wdata[6:0];
    m_stat = (m_stat & ~clr_m) | set_m;
    m_irq  = |(m_stat & m_ien);
  endtask

  task automatic tick();
    logic [15:0] exp_rd;
    @(posedge clk);
    if (m_live) model_step();
    @(negedge clk);
    case (reg_addr)
      2'd0:    exp_rd = m_ien;
      2'd1:    exp_rd = {8'h0, m_nak};
      2'd2:    exp_rd = {9'h0, m_addr};
      default: exp_rd = m_stat;
    endcase
    cmp(tag, reg_rdata, exp_rd);
    cmp("R7", {15'h0, irq}, {15'h0, m_irq});
    cmp("R9", {15'h0, addr_match}, {15'h0, tok_addr == m_addr});
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0; reg_wdata = 16'h0;
  endtask

  task automatic rd(logic [1:0] a);
    reg_addr = a;
    tick();
  endtask

  task automatic ev(logic [2:0] n, logic [2:0] r);
    ep_evt_valid = 1'b1; ep_evt_num = n; ep_evt_res = r;
    tick();
    ep_evt_valid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; reg_addr = 2'd0; reg_we = 1'b0; reg_wdata = 16'h0;
    ep_evt_valid = 1'b0; ep_evt_num = 3'd0; ep_evt_res = 3'd0;
    bus_reset_evt = 1'b0; sof_evt = 1'b0; id_evt = 1'b0; vbus_evt = 1'b0;
    tok_addr = 7'd0;
    m_ien = 16'h0; m_stat = 16'h0; m_nak = 8'h0; m_addr = 7'h0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) m_live = 1;

    // R10: reset values of every register
    tag = "R10";
    for (int a = 0; a < 4; a++) rd(2'(a));

    // R9: match on address 0 while stored address is 0, miss otherwise
    tag = "R9";
    tok_addr = 7'd0; rd(2'd2);
    tok_addr = 7'd5; rd(2'd2);

    // R8: upper bits ignored, value visible after the edge
    tag = "R8";
    wr(2'd2, 16'hFFA5);
    tok_addr = 7'h25; rd(2'd2);
    tok_addr = 7'h00; rd(2'd2);

    // R1: each counting result on different endpoints, enables off
    tag = "R1";
    reg_addr = 2'd3;
    ev(3'd0, 3'd0); ev(3'd3, 3'd2); ev(3'd5, 3'd3);
    ev(3'd6, 3'd4); ev(3'd7, 3'd5);

    // R2: NAK without enable, reserved codes, then NAK with enable
    tag = "R2";
    ev(3'd1, 3'd1); ev(3'd2, 3'd6); ev(3'd2, 3'd7);
    wr(2'd1, 16'hFF12);
    reg_addr = 2'd3;
    ev(3'd1, 3'd1); ev(3'd4, 3'd1); ev(3'd2, 3'd1);

    // R3: bus event strobes
    tag = "R3";
    bus_reset_evt = 1'b1; tick(); bus_reset_evt = 1'b0;
    sof_evt = 1'b1;       tick(); sof_evt = 1'b0;
    id_evt = 1'b1;        tick(); id_evt = 1'b0;
    vbus_evt = 1'b1;      tick(); vbus_evt = 1'b0;

    // R4: zeros keep flags, ones clear them
    tag = "R4";
    wr(2'd3, 16'h0000);
    wr(2'd3, 16'h0009);
    wr(2'd3, 16'h4200);

    // R5: set and clear meet on one bit
    tag = "R5";
    bus_reset_evt = 1'b1; wr(2'd3, 16'h0100); bus_reset_evt = 1'b0;
    ep_evt_valid = 1'b1; ep_evt_num = 3'd0; ep_evt_res = 3'd0;
    wr(2'd3, 16'h0001);
    ep_evt_valid = 1'b0;
    rd(2'd3);

    // R6: reserved bits in status and enable
    tag = "R6";
    wr(2'd3, 16'h3C00);
    wr(2'd0, 16'h3C00);

    // R7: interrupt follows enabled flags
    tag = "R7";
    wr(2'd0, 16'h0002);
    wr(2'd3, 16'h0002);
    wr(2'd0, 16'h8000);
    wr(2'd3, 16'h8000);
    reg_addr = 2'd3;
    vbus_evt = 1'b1; tick(); vbus_evt = 1'b0;
    rd(2'd3);

    summary();
  end
endmodule